// File: doc/BRIEF.md
# ADC Result Threshold Watchdog

This block watches the stream of conversion results from an analog-to-digital converter. Each result arrives with a one-cycle valid strobe, the index of the converter channel it came from, and a 10-bit value. Up to four watch slots can be configured. Each slot names the converter channel it follows and holds its own low and high limits. When a result for that channel lies outside the limits, a sticky pending flag for the slot is set.

There are eight pending flags, two for each slot. They sit in a status register that software clears by writing ones. A mask register with the same bit layout selects which flags may drive the single interrupt request line. The flagging rule is defined even when the high limit has been programmed below the low limit: in that case exactly one flag of the pair is set for any result that is not equal to the low limit.

Software sets limits, channel assignments and masks through a simple single-cycle write port. Reads are combinational, from the same address.

Top module: `adc_wdog_monitor`

## Requirements
- R1: After a synchronous active-low reset, status and mask read 0 and `irq` is low. Each slot k has a low limit of 0, a high limit of 1023, and follows converter channel k.
- R2: A valid result on a slot's channel that is strictly below the slot's low limit sets status bit 2k (the low flag of slot k). The flag is readable in the cycle after the strobe.
- R3: When the high limit is not below the low limit, a valid result strictly above the high limit sets status bit 2k+1 (the high flag of slot k).
- R4: The comparisons are strict. A result equal to either limit, or lying between the limits, sets no flag.
- R5: When the high limit is below the low limit, a result under the low limit sets only the low flag. Any result above the low limit sets only the high flag. A result equal to the low limit sets neither flag.
- R6: Pending flags are sticky. Later in-range results do not clear them, and a clear written to other bits leaves them set.
- R7: Writing to the status register (address 16) clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: If a result sets a flag in the same cycle that a status write clears that flag, the flag ends up set.
- R9: `irq` is high exactly while some status bit and the matching mask bit (address 17, same bit layout) are both 1.
- R10: A result is ignored when `res_valid` is low or when its channel is not followed by any slot. Several slots that follow the same channel each evaluate that result.
- R11: Register addresses are as follows. For slot k, address 4k holds the low limit, 4k+1 the high limit and 4k+2 the followed channel. Address 16 is the status register and 17 is the mask register. Reads return the value zero-extended, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_chan | input | 5 | Converter channel index of the result |
| res_data | input | 10 | Conversion result value |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address for writes and reads |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request, high while an enabled flag is pending |

## Verification
The bound checker covers the rules that hold on every cycle. These are: pending bits never drop except under a status write; no bit rises without a result strobe; a slot never gains both flags from one result; and the interrupt line agrees with the enabled pending bits. The actual limit arithmetic can only be shown by the directed scenarios, which drive known results and read back exact status values. These cover strict equality at both limits, the inverted-limit rule, the set-over-clear collision, channel reassignment and shared channels.

// File: rtl/adc_wdog_pkg.sv
// Package: shared sizes for the ADC threshold watchdog.
// Assumes: one result per cycle at most; four watch slots by default.
package adc_wdog_pkg;
    localparam int NUM_SLOTS_D = 4;   // watch slots
    localparam int RES_W_D     = 10;  // result width
    localparam int CH_W_D      = 5;   // converter channel index width
    localparam int ADDR_W_D    = 5;   // register address width
    localparam int DATA_W_D    = 10;  // register data width (>= RES_W, >= 2*slots)

    // Field offsets inside one slot's 4-address window
    typedef enum logic [1:0] {
        FLD_LO  = 2'd0,
        FLD_HI  = 2'd1,
        FLD_SEL = 2'd2,
        FLD_RSV = 2'd3
    } slot_fld_e;
endpackage

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Holds per-slot limits and channel selection plus the interrupt mask.
// Decodes writes, produces the write-one-to-clear vector for the status
// register, and serves combinational reads. Assumes DATA_W covers RES_W,
// CH_W and 2*NUM_SLOTS.
module wdog_regs
    import adc_wdog_pkg::*;
#(
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    parameter int RES_W     = RES_W_D,
    parameter int CH_W      = CH_W_D,
    parameter int ADDR_W    = ADDR_W_D,
    parameter int DATA_W    = DATA_W_D
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [2*NUM_SLOTS-1:0]          pend,
    output logic [NUM_SLOTS-1:0][RES_W-1:0] lo_thr,
    output logic [NUM_SLOTS-1:0][RES_W-1:0] hi_thr,
    output logic [NUM_SLOTS-1:0][CH_W-1:0]  ch_sel,
    output logic [2*NUM_SLOTS-1:0]          mask,
    output logic [2*NUM_SLOTS-1:0]          clr_vec,
    output logic [DATA_W-1:0]               rdata
);
    localparam int PW          = 2 * NUM_SLOTS;
    localparam int ADDR_STATUS = 4 * NUM_SLOTS;
    localparam int ADDR_MASK   = 4 * NUM_SLOTS + 1;

    logic [PW-1:0] mask_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [RES_W-1:0] lo_r;
        logic [RES_W-1:0] hi_r;
        logic [CH_W-1:0]  sel_r;

        // Purpose: hold slot k limits and followed channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_r  <= '0;
                hi_r  <= '1;
                sel_r <= CH_W'(k);
            end else if (wr) begin
                if (addr == ADDR_W'(4*k + int'(FLD_LO)))  lo_r  <= wdata[RES_W-1:0];
                if (addr == ADDR_W'(4*k + int'(FLD_HI)))  hi_r  <= wdata[RES_W-1:0];
                if (addr == ADDR_W'(4*k + int'(FLD_SEL))) sel_r <= wdata[CH_W-1:0];
            end
        end

        assign lo_thr[k] = lo_r;
        assign hi_thr[k] = hi_r;
        assign ch_sel[k] = sel_r;
    end

    // Purpose: hold the interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mask_q <= '0;
        else if (wr && addr == ADDR_W'(ADDR_MASK))    mask_q <= wdata[PW-1:0];
    end

    assign mask    = mask_q;
    assign clr_vec = (wr && addr == ADDR_W'(ADDR_STATUS)) ? wdata[PW-1:0] : '0;

    // Purpose: combinational register read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_STATUS)) rdata = DATA_W'(pend);
        if (addr == ADDR_W'(ADDR_MASK))   rdata = DATA_W'(mask_q);
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (addr == ADDR_W'(4*k + int'(FLD_LO)))  rdata = DATA_W'(lo_thr[k]);
            if (addr == ADDR_W'(4*k + int'(FLD_HI)))  rdata = DATA_W'(hi_thr[k]);
            if (addr == ADDR_W'(4*k + int'(FLD_SEL))) rdata = DATA_W'(ch_sel[k]);
        end
    end
endmodule

// File: rtl/wdog_compare.sv
// Module: wdog_compare
// One watch slot's limit check. Purely combinational: raises a low or high
// set request for a valid result on the followed channel. With inverted
// limits the high request compares against the low limit so that the two
// requests stay mutually exclusive. Comparisons are strict.
module wdog_compare #(
    parameter int RES_W = 10,
    parameter int CH_W  = 5
) (
    input  logic             res_valid,
    input  logic [CH_W-1:0]  res_chan,
    input  logic [RES_W-1:0] res_data,
    input  logic [RES_W-1:0] lo_thr,
    input  logic [RES_W-1:0] hi_thr,
    input  logic [CH_W-1:0]  ch_sel,
    output logic             set_lo,
    output logic             set_hi
);
    logic hit;
    logic below_lo;
    logic above_lo;
    logic above_hi;
    logic inverted;

    assign hit      = res_valid && (res_chan == ch_sel);
    assign below_lo = res_data < lo_thr;
    assign above_lo = res_data > lo_thr;
    assign above_hi = res_data > hi_thr;
    assign inverted = hi_thr < lo_thr;

    assign set_lo = hit && below_lo;
    assign set_hi = hit && (inverted ? above_lo : above_hi);
endmodule

// File: rtl/wdog_status.sv
// Module: wdog_status
// Sticky pending flags with write-one-to-clear; a set in the same cycle as
// a clear wins. Drives the interrupt from pending AND mask.
module wdog_status #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] set_vec,
    input  logic [PW-1:0] clr_vec,
    input  logic [PW-1:0] mask,
    output logic [PW-1:0] pend,
    output logic          irq
);
    logic [PW-1:0] pend_q;

    // Purpose: update sticky pending flags, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & mask);
endmodule

// File: rtl/adc_wdog_monitor.sv
// Module: adc_wdog_monitor (top)
// ADC result threshold watchdog: per-slot limit checks, sticky status,
// mask and one interrupt line, configured through a simple register port.
// Assumes at most one result per cycle and synchronous active-low reset.
module adc_wdog_monitor
    import adc_wdog_pkg::*;
#(
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    parameter int RES_W     = RES_W_D,
    parameter int CH_W      = CH_W_D,
    parameter int ADDR_W    = ADDR_W_D,
    parameter int DATA_W    = DATA_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [RES_W-1:0]  res_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PW = 2 * NUM_SLOTS;

    logic [NUM_SLOTS-1:0][RES_W-1:0] lo_thr;
    logic [NUM_SLOTS-1:0][RES_W-1:0] hi_thr;
    logic [NUM_SLOTS-1:0][CH_W-1:0]  ch_sel;
    logic [PW-1:0]                   mask_vec;
    logic [PW-1:0]                   clr_vec;
    logic [PW-1:0]                   set_vec;
    logic [PW-1:0]                   pend_vec;

    wdog_regs #(
        .NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W), .CH_W(CH_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend    (pend_vec),
        .lo_thr  (lo_thr),
        .hi_thr  (hi_thr),
        .ch_sel  (ch_sel),
        .mask    (mask_vec),
        .clr_vec (clr_vec),
        .rdata   (reg_rdata)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        wdog_compare #(.RES_W(RES_W), .CH_W(CH_W)) u_cmp (
            .res_valid (res_valid),
            .res_chan  (res_chan),
            .res_data  (res_data),
            .lo_thr    (lo_thr[k]),
            .hi_thr    (hi_thr[k]),
            .ch_sel    (ch_sel[k]),
            .set_lo    (set_vec[2*k]),
            .set_hi    (set_vec[2*k+1])
        );
    end

    wdog_status #(.PW(PW)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (mask_vec),
        .pend    (pend_vec),
        .irq     (irq)
    );
endmodule

// File: rtl/adc_wdog_monitor_chk.sv
// Module: adc_wdog_monitor_chk
// Cycle-by-cycle rules on the watchdog's status flags and interrupt line.
// Bound to every adc_wdog_monitor instance. The clear vector is rebuilt
// here from the register port, not taken from the design.
module adc_wdog_monitor_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   res_valid,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [2*NUM_SLOTS-1:0] reg_wdata_lo,
    input logic                   irq,
    input logic [2*NUM_SLOTS-1:0] pend,
    input logic [2*NUM_SLOTS-1:0] mask
);
    localparam int PW = 2 * NUM_SLOTS;

    logic [PW-1:0] clr_seen;
    assign clr_seen = (reg_wr && reg_addr == ADDR_W'(4 * NUM_SLOTS)) ? reg_wdata_lo : '0;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend == '0));  // R1

    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr_seen)) & ~pend) == '0);  // R6

    AST_SET_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(res_valid) |-> ((pend & ~$past(pend)) == '0));  // R10

    AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & mask) != '0));  // R9

    AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) != '0) |-> irq);  // R9

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_excl
        AST_ONE_FLAG_PER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(res_valid) |-> !((pend[2*k] && !$past(pend[2*k])) &&
                                   (pend[2*k+1] && !$past(pend[2*k+1]))));  // R5
    end
endmodule

bind adc_wdog_monitor adc_wdog_monitor_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata_lo (reg_wdata[2*NUM_SLOTS-1:0]),
    .irq          (irq),
    .pend         (pend_vec),
    .mask         (mask_vec)
);

// File: tb/adc_wdog_monitor_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module adc_wdog_monitor_tb;
    localparam int A_STATUS = 16;
    localparam int A_MASK   = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [4:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    adc_wdog_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All helpers start and end just after a falling edge.
    task automatic wr(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 10'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 5'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic result(input int ch, input int val);
        res_valid = 1'b1; res_chan = 5'(ch); res_data = 10'(val);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic chk_status(input string req, input int exp);
        int v;
        rd(A_STATUS, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        int v;
        chk_status("R1 status", 0);
        rd(A_MASK, v); chk("R1 mask", v, 0);
        chk("R1 irq", int'(irq), 0);
        rd(0, v); chk("R1 lo0", v, 0);
        rd(1, v); chk("R1 hi0", v, 1023);
        rd(10, v); chk("R1 sel2", v, 2);
        rd(3, v); chk("R11 unmapped", v, 0);
    endtask

    task automatic t_low_high();
        int v;
        wr(0, 100); wr(1, 900);
        rd(0, v); chk("R11 lo0 readback", v, 100);
        result(0, 50);  chk_status("R2 low flag", 'h01);
        wr(A_STATUS, 'h01); chk_status("R7 clear low", 0);
        result(0, 950); chk_status("R3 high flag", 'h02);
        wr(A_STATUS, 'h02); chk_status("R7 clear high", 0);
    endtask

    task automatic t_strict();
        result(0, 100); chk_status("R4 equal low", 0);
        result(0, 900); chk_status("R4 equal high", 0);
        result(0, 500); chk_status("R4 inside", 0);
    endtask

    task automatic t_inverted();
        wr(4, 600); wr(5, 200);
        result(1, 100); chk_status("R5 below both", 'h04);
        wr(A_STATUS, 'h04);
        result(1, 400); chk_status("R5 between", 'h04);
        wr(A_STATUS, 'h04);
        result(1, 700); chk_status("R5 above low", 'h08);
        wr(A_STATUS, 'h08);
        result(1, 600); chk_status("R5 equal low", 0);
    endtask

    task automatic t_sticky();
        result(0, 50);  chk_status("R6 set", 'h01);
        result(0, 500); chk_status("R6 kept after in-range", 'h01);
        wr(A_STATUS, 'h02); chk_status("R6 other bit cleared", 'h01);
        wr(A_STATUS, 'h00); chk_status("R7 zero write", 'h01);
        wr(A_STATUS, 'h01); chk_status("R7 cleared", 0);
    endtask

    task automatic t_set_wins();
        result(0, 950); result(0, 50);
        chk_status("R8 both pending", 'h03);
        res_valid = 1'b1; res_chan = 5'd0; res_data = 10'd50;
        reg_wr = 1'b1; reg_addr = 5'(A_STATUS); reg_wdata = 10'h003;
        @(negedge clk);
        res_valid = 1'b0; reg_wr = 1'b0;
        chk_status("R8 set beats clear", 'h01);
        wr(A_STATUS, 'h3FF); chk_status("R7 clear all", 0);
    endtask

    task automatic t_irq();
        int v;
        wr(A_MASK, 'h04);
        rd(A_MASK, v); chk("R9 mask readback", v, 'h04);
        result(0, 50);
        chk("R9 masked flag no irq", int'(irq), 0);
        result(1, 100);
        chk("R9 enabled flag irq", int'(irq), 1);
        wr(A_STATUS, 'h04);
        chk("R9 irq drops", int'(irq), 0);
        chk_status("R9 unmasked flag kept", 'h01);
        wr(A_STATUS, 'h3FF); wr(A_MASK, 0);
    endtask

    task automatic t_assign();
        wr(8, 100); wr(10, 9);
        result(2, 50);  chk_status("R10 unassigned channel", 0);
        res_chan = 5'd0; res_data = 10'd50; @(negedge clk);
        chk_status("R10 no strobe", 0);
        result(9, 50);  chk_status("R10 reassigned slot", 'h10);
        wr(A_STATUS, 'h10);
        wr(12, 100); wr(14, 9);
        result(9, 50);  chk_status("R10 shared channel", 'h50);
        wr(A_STATUS, 'h3FF);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_high();
        t_strict();
        t_inverted();
        t_sticky();
        t_set_wins();
        t_irq();
        t_assign();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule